// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between a 32-bit processor datapath and a byte-addressed data memory port. On the store side it takes the register value, the two low address bits and the access size. It drives write data with the value copied across the lanes, plus one write enable per byte lane. On the load side it takes the raw memory word, the same address bits and size, and a signed/unsigned select. It returns the addressed byte, halfword or word, extended to 32 bits. Accesses that are not aligned to their size, and the reserved size code, are flagged as misaligned and suppressed.

Byte-lane ordering comes from an endianness strap. A two-state mode machine holds it. The states are MODE_LITTLE, where offset 0 is bits 7:0, and MODE_BIG, where offset 0 is bits 31:24. The machine has three transitions. RESET_TO_LITTLE is taken on a clock edge with reset low and the strap at 0. RESET_TO_BIG is taken on a clock edge with reset low and the strap at 1. HOLD keeps the current state on every edge with reset high. The alignment paths themselves are combinational, so results follow the inputs within the same cycle.

Top module: `lsa_align`

## Requirements
- R1: Byte load (acc_size 2'b00) returns the byte at offset addr_lo in bits 7:0. In little-endian mode that byte is in lane addr_lo; in big-endian mode it is in lane 3-addr_lo (lane n is bits 8n+7:8n). Bits 31:8 are copies of bit 7 when ld_signed is 1, and zero when ld_signed is 0.
- R2: Halfword load (acc_size 2'b01, addr_lo 0 or 2) combines the addressed byte and the next one. The addressed byte is the low half in little-endian mode and the high half in big-endian mode. Bits 31:16 are copies of bit 15 when ld_signed is 1, and zero when ld_signed is 0.
- R3: Word load (acc_size 2'b10, addr_lo 0) returns the memory word unchanged in either mode.
- R4: Store write data is the low byte copied four times for a byte store, the low halfword copied twice for a halfword store, and the full register for a word store or the reserved size.
- R5: With wr_req high and the access aligned, wr_be has a bit set for exactly the lanes that hold the addressed bytes. A byte sets one lane, a halfword sets two and a word sets all four. Lanes are mapped per mode as in R1.
- R6: misalign is high for a halfword with addr_lo[0]=1, for a word with addr_lo not 0, and for acc_size 2'b11. While it is high, wr_be is 0 and ld_result is 0.
- R7: The mode is taken from big_endian_strap (1 = big-endian) on each clock edge while rst_n is low. Changes of the strap while rst_n is high have no effect.
- R8: With wr_req low, wr_be is 0, including while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the strap is sampled while it is low |
| big_endian_strap | input | 1 | 1 selects big-endian lane order, 0 little-endian |
| acc_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| addr_lo | input | 2 | Byte offset of the access within the word |
| ld_signed | input | 1 | 1 sign-extends, 0 zero-extends load results |
| wr_req | input | 1 | Store request; gates the byte enables |
| st_data | input | 32 | Source register value for stores |
| ld_word | input | 32 | Raw word read from memory |
| wr_data | output | 32 | Store data, copied across lanes |
| wr_be | output | 4 | Per-lane write enables, bit n for bits 8n+7:8n |
| ld_result | output | 32 | Extracted and extended load value |
| misalign | output | 1 | Access not aligned to its size, or reserved size |

## Verification
Every data result (wr_data, wr_be, ld_result, misalign) depends on the inputs and the stored mode through combinational logic only. A result is due in the same cycle its inputs are applied. The one exception is the mode, which takes a new strap value at the first rising edge with reset low. The driver changes inputs one time unit after a rising edge and queues the expected values. The monitor pops and compares them at the next falling edge, half a cycle later, so no rising edge falls between stimulus and sample. Mode checks are made only after at least one reset edge. The strap-ignored check flips the strap, waits several edges with reset high, and then checks a byte load, whose lane selection shows the held mode.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    typedef enum logic {
        MODE_LITTLE = 1'b0,
        MODE_BIG    = 1'b1
    } mode_e;

endpackage

// File: rtl/lsa_mode_fsm.sv
module lsa_mode_fsm
    import lsa_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  strap,
    output mode_e mode
);

    mode_e state_q;
    mode_e state_d;

    // state register
    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    // transitions: RESET_TO_BIG / RESET_TO_LITTLE while in reset, HOLD otherwise
    always_comb begin
        state_d = state_q;
        if (!rst_n) begin
            state_d = strap ? MODE_BIG : MODE_LITTLE;
        end else begin
            unique case (state_q)
                MODE_LITTLE: state_d = MODE_LITTLE;
                MODE_BIG:    state_d = MODE_BIG;
            endcase
        end
    end

    // outputs
    always_comb begin
        mode = state_q;
    end

endmodule

// File: rtl/lsa_store_lane.sv
module lsa_store_lane
    import lsa_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int OFF_W  = $clog2(LANES)
) (
    input  mode_e              mode,
    input  size_e              size,
    input  logic [OFF_W-1:0]   off,
    input  logic               wr_req,
    input  logic               misalign,
    input  logic [DATA_W-1:0]  st_data,
    output logic [DATA_W-1:0]  wr_data,
    output logic [LANES-1:0]   wr_be
);

    localparam int CW = OFF_W + 2;

    logic [CW-1:0] span;
    logic [CW-1:0] first;
    logic [CW-1:0] last_x;

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                span    = CW'(1);
                wr_data = {LANES{st_data[7:0]}};
            end
            SZ_HALF: begin
                span    = CW'(2);
                wr_data = {(LANES/2){st_data[15:0]}};
            end
            default: begin
                span    = CW'(LANES);
                wr_data = st_data;
            end
        endcase
        first  = CW'(off);
        last_x = first + span;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [CW-1:0] LE_OFF = CW'(i);
        localparam logic [CW-1:0] BE_OFF = CW'(LANES - 1 - i);
        logic [CW-1:0] lane_off;
        logic          covered;
        assign lane_off = (mode == MODE_BIG) ? BE_OFF : LE_OFF;
        assign covered  = (lane_off >= first) && (lane_off < last_x);
        assign wr_be[i] = wr_req & ~misalign & covered;
    end

endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
    import lsa_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int OFF_W  = $clog2(LANES)
) (
    input  mode_e              mode,
    input  size_e              size,
    input  logic [OFF_W-1:0]   off,
    input  logic               ld_signed,
    input  logic               misalign,
    input  logic [DATA_W-1:0]  ld_word,
    output logic [DATA_W-1:0]  ld_result
);

    logic [7:0] lane_byte [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_unpack
        assign lane_byte[i] = ld_word[8*i +: 8];
    end

    function automatic logic [OFF_W-1:0] phys_lane(input logic [OFF_W-1:0] k, input mode_e m);
        return (m == MODE_BIG) ? ~k : k;
    endfunction

    logic [7:0]  b_first;
    logic [7:0]  b_next;
    logic [15:0] half_v;

    always_comb begin
        b_first = lane_byte[phys_lane(off, mode)];
        b_next  = lane_byte[phys_lane(off + 1'b1, mode)];
        half_v  = (mode == MODE_BIG) ? {b_first, b_next} : {b_next, b_first};
        if (misalign) begin
            ld_result = '0;
        end else begin
            unique case (size)
                SZ_BYTE: ld_result = {{(DATA_W-8){ld_signed & b_first[7]}}, b_first};
                SZ_HALF: ld_result = {{(DATA_W-16){ld_signed & half_v[15]}}, half_v};
                SZ_WORD: ld_result = ld_word;
                default: ld_result = '0;
            endcase
        end
    end

endmodule

// File: rtl/lsa_align.sv
module lsa_align
    import lsa_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int OFF_W  = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              big_endian_strap,
    input  logic [1:0]        acc_size,
    input  logic [OFF_W-1:0]  addr_lo,
    input  logic              ld_signed,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] st_data,
    input  logic [DATA_W-1:0] ld_word,
    output logic [DATA_W-1:0] wr_data,
    output logic [LANES-1:0]  wr_be,
    output logic [DATA_W-1:0] ld_result,
    output logic              misalign
);

    mode_e mode;
    size_e size;

    assign size = size_e'(acc_size);

    lsa_mode_fsm u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .strap (big_endian_strap),
        .mode  (mode)
    );

    always_comb begin
        unique case (size)
            SZ_BYTE: misalign = 1'b0;
            SZ_HALF: misalign = addr_lo[0];
            SZ_WORD: misalign = |addr_lo;
            default: misalign = 1'b1;
        endcase
    end

    lsa_store_lane #(.DATA_W(DATA_W)) u_store (
        .mode     (mode),
        .size     (size),
        .off      (addr_lo),
        .wr_req   (wr_req),
        .misalign (misalign),
        .st_data  (st_data),
        .wr_data  (wr_data),
        .wr_be    (wr_be)
    );

    lsa_load_extract #(.DATA_W(DATA_W)) u_load (
        .mode      (mode),
        .size      (size),
        .off       (addr_lo),
        .ld_signed (ld_signed),
        .misalign  (misalign),
        .ld_word   (ld_word),
        .ld_result (ld_result)
    );

endmodule

// File: rtl/lsa_align_chk.sv
module lsa_align_chk #(
    parameter  int DATA_W = 32,
    localparam int LANES  = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        acc_size,
    input logic              ld_signed,
    input logic              wr_req,
    input logic [LANES-1:0]  wr_be,
    input logic [DATA_W-1:0] ld_result,
    input logic              misalign,
    input logic              mode
);

    p_misalign_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (wr_be == '0 && ld_result == '0));

    p_idle_no_be_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |-> (wr_be == '0));

    p_byte_be_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !misalign && acc_size == 2'b00) |-> ($countones(wr_be) == 1));

    p_half_be_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !misalign && acc_size == 2'b01) |-> ($countones(wr_be) == 2));

    p_word_be_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !misalign && acc_size == 2'b10) |-> (&wr_be));

    p_byte_ext_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!misalign && acc_size == 2'b00) |->
            (ld_result[DATA_W-1:8] == {(DATA_W-8){ld_signed & ld_result[7]}}));

    p_half_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!misalign && acc_size == 2'b01) |->
            (ld_result[DATA_W-1:16] == {(DATA_W-16){ld_signed & ld_result[15]}}));

    p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode));

endmodule

bind lsa_align lsa_align_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_size  (acc_size),
    .ld_signed (ld_signed),
    .wr_req    (wr_req),
    .wr_be     (wr_be),
    .ld_result (ld_result),
    .misalign  (misalign),
    .mode      (mode)
);

// File: tb/lsa_align_test.sv
module lsa_align_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        big_endian_strap;
    logic [1:0]  acc_size;
    logic [1:0]  addr_lo;
    logic        ld_signed;
    logic        wr_req;
    logic [31:0] st_data;
    logic [31:0] ld_word;
    logic [31:0] wr_data;
    logic [3:0]  wr_be;
    logic [31:0] ld_result;
    logic        misalign;

    always #5 clk = ~clk;

    lsa_align uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .big_endian_strap (big_endian_strap),
        .acc_size         (acc_size),
        .addr_lo          (addr_lo),
        .ld_signed        (ld_signed),
        .wr_req           (wr_req),
        .st_data          (st_data),
        .ld_word          (ld_word),
        .wr_data          (wr_data),
        .wr_be            (wr_be),
        .ld_result        (ld_result),
        .misalign         (misalign)
    );

    typedef struct {
        string       tag;
        logic [31:0] wd;
        logic [3:0]  be;
        logic [31:0] ld;
        logic        mis;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    function automatic int lane_of(input int k, input bit big);
        return big ? (3 - (k % 4)) : (k % 4);
    endfunction

    function automatic exp_t model(input string tag, input logic [1:0] sz, input logic [1:0] off,
                                   input bit sgn, input bit wr, input logic [31:0] st,
                                   input logic [31:0] w, input bit big);
        exp_t e;
        int   n;
        logic [7:0]  a;
        logic [7:0]  b;
        logic [15:0] h;
        e.tag = tag;
        n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 0;
        e.mis = (sz == 2'd3) || (sz == 2'd1 && off[0]) || (sz == 2'd2 && off != 2'd0);
        if (sz == 2'd0)      e.wd = {st[7:0], st[7:0], st[7:0], st[7:0]};
        else if (sz == 2'd1) e.wd = {st[15:0], st[15:0]};
        else                 e.wd = st;
        e.be = 4'b0000;
        if (wr && !e.mis)
            for (int k = 0; k < n; k++) e.be[lane_of(int'(off) + k, big)] = 1'b1;
        a = w[8*lane_of(int'(off), big) +: 8];
        b = w[8*lane_of(int'(off) + 1, big) +: 8];
        h = big ? {a, b} : {b, a};
        if (e.mis)           e.ld = 32'h0;
        else if (sz == 2'd0) e.ld = sgn ? {{24{a[7]}}, a} : {24'h0, a};
        else if (sz == 2'd1) e.ld = sgn ? {{16{h[15]}}, h} : {16'h0, h};
        else                 e.ld = w;
        return e;
    endfunction

    bit cur_big = 0;

    task automatic drive(input string tag, input logic [1:0] sz, input logic [1:0] off,
                         input bit sgn, input bit wr, input logic [31:0] st, input logic [31:0] w);
        @(posedge clk);
        #1;
        acc_size  = sz;
        addr_lo   = off;
        ld_signed = sgn;
        wr_req    = wr;
        st_data   = st;
        ld_word   = w;
        q.push_back(model(tag, sz, off, sgn, wr, st, w, cur_big));
    endtask

    task automatic do_reset(input bit strap);
        @(posedge clk);
        #1;
        rst_n            = 1'b0;
        big_endian_strap = strap;
        wr_req           = 1'b0;
        cur_big          = strap;
        repeat (2) @(posedge clk);
        // reset state: no enables while in reset (R8)
        drive("R8 reset", 2'd0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    // monitor: compares at the falling edge after each stimulus
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (wr_data !== e.wd || wr_be !== e.be || ld_result !== e.ld || misalign !== e.mis) begin
                    errors++;
                    $display("FAIL %s: wr_data=%h wr_be=%b ld=%h mis=%b expected wr_data=%h wr_be=%b ld=%h mis=%b",
                             e.tag, wr_data, wr_be, ld_result, misalign, e.wd, e.be, e.ld, e.mis);
                end
            end
        end
    end

    task automatic run_set(input string mtag);
        logic [31:0] w1;
        logic [31:0] w2;
        w1 = 32'hA1B2C3D4;
        w2 = 32'h7F01_0280;
        for (int o = 0; o < 4; o++) begin
            drive({"R1 byte signed ", mtag}, 2'd0, 2'(o), 1'b1, 1'b0, 32'h0, w1);
            drive({"R1 byte unsigned ", mtag}, 2'd0, 2'(o), 1'b0, 1'b0, 32'h0, w1);
            drive({"R1 byte signed pos ", mtag}, 2'd0, 2'(o), 1'b1, 1'b0, 32'h0, w2);
        end
        for (int o = 0; o < 4; o += 2) begin
            drive({"R2 half signed ", mtag}, 2'd1, 2'(o), 1'b1, 1'b0, 32'h0, w1);
            drive({"R2 half unsigned ", mtag}, 2'd1, 2'(o), 1'b0, 1'b0, 32'h0, w1);
            drive({"R2 half signed mix ", mtag}, 2'd1, 2'(o), 1'b1, 1'b0, 32'h0, w2);
        end
        drive({"R3 word ", mtag}, 2'd2, 2'd0, 1'b1, 1'b0, 32'h0, w1);
        for (int o = 0; o < 4; o++)
            drive({"R4 R5 byte store ", mtag}, 2'd0, 2'(o), 1'b0, 1'b1, 32'h1234_56E7, 32'h0);
        for (int o = 0; o < 4; o += 2)
            drive({"R4 R5 half store ", mtag}, 2'd1, 2'(o), 1'b0, 1'b1, 32'h1234_B6E7, 32'h0);
        drive({"R4 R5 word store ", mtag}, 2'd2, 2'd0, 1'b0, 1'b1, 32'hDEAD_BEEF, 32'h0);
        drive({"R8 store idle ", mtag}, 2'd2, 2'd0, 1'b0, 1'b0, 32'hDEAD_BEEF, w1);
        drive({"R6 half odd ", mtag}, 2'd1, 2'd1, 1'b1, 1'b1, 32'h5555_AAAA, w1);
        drive({"R6 half off3 ", mtag}, 2'd1, 2'd3, 1'b0, 1'b1, 32'h5555_AAAA, w1);
        drive({"R6 word off2 ", mtag}, 2'd2, 2'd2, 1'b0, 1'b1, 32'h5555_AAAA, w1);
        drive({"R6 word off1 ", mtag}, 2'd2, 2'd1, 1'b0, 1'b1, 32'h5555_AAAA, w1);
        drive({"R6 reserved size ", mtag}, 2'd3, 2'd0, 1'b0, 1'b1, 32'h5555_AAAA, w1);
    endtask

    initial begin
        rst_n            = 1'b0;
        big_endian_strap = 1'b0;
        acc_size         = 2'd0;
        addr_lo          = 2'd0;
        ld_signed        = 1'b0;
        wr_req           = 1'b0;
        st_data          = 32'h0;
        ld_word          = 32'h0;

        do_reset(1'b0);
        run_set("LE");

        // R7: strap change with reset high must be ignored
        @(posedge clk);
        #1;
        big_endian_strap = 1'b1;
        repeat (4) @(posedge clk);
        drive("R7 strap ignored byte", 2'd0, 2'd0, 1'b0, 1'b0, 32'h0, 32'hA1B2C3D4);
        drive("R7 strap ignored be", 2'd0, 2'd1, 1'b0, 1'b1, 32'h0000_0099, 32'h0);

        // R7: new strap value taken at reset
        do_reset(1'b1);
        run_set("BE");
        @(posedge clk);
        #1;
        big_endian_strap = 1'b0;
        repeat (4) @(posedge clk);
        drive("R7 strap ignored big", 2'd0, 2'd0, 1'b0, 1'b0, 32'h0, 32'hA1B2C3D4);

        repeat (3) @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule